// File: doc/BRIEF.md
# Invalidation Acknowledgement Counter and Response Classifier

This block sits beside the transaction table of a cache controller that uses write-invalidate coherence. While a line waits for write permission, the controller must gather one invalidation acknowledgement from every former sharer. Those acknowledgements can come back before or after the directory's data reply. Each reply names how many acknowledgements to expect.

For each response that arrives, the controller hands the block three things: the message (whether it came from the directory, its kind, and its ack count), whether a transaction record exists for the line, and the record's signed ack counter. One cycle later the block returns a coherence event code, an error code, and a write-back of the new counter value. Acknowledgements that arrive early drive the counter negative. The directory reply then adds its count, so a result of zero means every acknowledgement is already in. The block also gives the zero value for a counter whose record is being allocated.

Top module: `inv_ack_tracker`

## Requirements
- R1: When `alloc_i` is high, one cycle later `cnt_we_o` is 1, `cnt_new_o` is 0 and `evt_o` is 0 (none).
- R2: A peer response of kind invalidation-ack (`rsp_kind_i`=1, `rsp_from_dir_i`=0), for a line whose counter is neither 1 nor at or below -MAX_SHARERS, gives `evt_o`=4 (ack). It also writes the counter minus one, and that value may be negative.
- R3: A peer invalidation-ack arriving while the counter equals exactly 1 gives `evt_o`=5 (last ack) and writes 0.
- R4: A directory response of kind data (`rsp_kind_i`=0) whose ack count plus counter equals 0 gives `evt_o`=1 (data, no acks pending) and writes 0.
- R5: A directory data response whose sum lies in 1..MAX_SHARERS gives `evt_o`=2 (data, acks pending) and writes the sum. The stored count is therefore always positive.
- R6: A directory data response whose sum is negative or above MAX_SHARERS gives `err_o`=4, `evt_o`=0 and no counter write.
- R7: A peer data response gives `evt_o`=3 (owner data) and no counter write.
- R8: A directory response of any kind other than data gives `err_o`=2. A peer response of kind 2 or 3 gives `err_o`=3. In both cases there is no event and no write.
- R9: A response for a line with no record (`rec_present_i`=0), or one presented in the same cycle as `alloc_i`, gives `err_o`=1 and no event. In the same-cycle case the allocation write of R1 still occurs.
- R10: A peer invalidation-ack for a counter at or below -MAX_SHARERS gives `err_o`=5 (underflow), no event and no write.
- R11: All outputs are registered one cycle after the inputs. They are zero during reset and in any cycle following one with neither a response nor an allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | A transaction record is being allocated; clear its counter |
| rsp_valid_i | input | 1 | A response is presented this cycle |
| rsp_from_dir_i | input | 1 | 1 = sender is the directory, 0 = a peer cache |
| rsp_kind_i | input | 2 | 0 data, 1 invalidation-ack, 2/3 other |
| rsp_acks_i | input | ACK_W | Ack count carried by a directory data reply |
| rec_present_i | input | 1 | The line has a transaction record |
| rec_count_i | input | CNT_W | Signed ack counter read from the record |
| evt_o | output | 3 | Event: 0 none, 1 data no acks, 2 data with acks, 3 owner data, 4 ack, 5 last ack |
| err_o | output | 3 | Error: 0 none, 1 no record, 2 directory type, 3 peer type, 4 sum range, 5 underflow |
| cnt_we_o | output | 1 | Write `cnt_new_o` back to the record |
| cnt_new_o | output | CNT_W | Signed counter value to store |

## Verification
The bench builds the block with MAX_SHARERS=7, which gives a 4-bit signed counter (-8..7). At that size the negative floor (-7, the underflow error) is easy to reach, and so is a sum one past the limit (8). Both ends of the representable range are exercised as well. Directed sequences cover acknowledgements that arrive before the directory data and after it. Randomized responses then sweep every kind, sender and counter value against a behavioural model.

// File: rtl/inv_ack_pkg.sv
package inv_ack_pkg;
  typedef enum logic [1:0] {
    KIND_DATA   = 2'd0,
    KIND_INVACK = 2'd1
  } rsp_kind_e;

  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_DIR_CLEAR = 3'd1,
    EV_DIR_WAIT  = 3'd2,
    EV_OWNER     = 3'd3,
    EV_ACK       = 3'd4,
    EV_LAST      = 3'd5
  } evt_e;

  typedef enum logic [2:0] {
    ER_NONE     = 3'd0,
    ER_NOREC    = 3'd1,
    ER_DIRTYPE  = 3'd2,
    ER_PEERTYPE = 3'd3,
    ER_RANGE    = 3'd4,
    ER_UNDER    = 3'd5
  } err_e;
endpackage

// File: rtl/iat_count_math.sv
module iat_count_math #(
  parameter int MAX_SHARERS = 15,
  localparam int ACK_W = $clog2(MAX_SHARERS + 1),
  localparam int CNT_W = ACK_W + 1,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic signed [CNT_W-1:0] count_i,
  input  logic        [ACK_W-1:0] acks_i,
  output logic signed [CNT_W-1:0] sum_o,
  output logic                    sum_zero_o,
  output logic                    sum_bad_o,
  output logic signed [CNT_W-1:0] dec_o,
  output logic                    at_floor_o,
  output logic                    is_one_o
);
  logic signed [SUM_W-1:0] wide_sum;
  logic signed [SUM_W-1:0] limit;

  always_comb begin
    wide_sum   = SUM_W'(count_i) + $signed({2'b00, acks_i});
    limit      = SUM_W'(MAX_SHARERS);
    sum_o      = wide_sum[CNT_W-1:0];
    sum_zero_o = (wide_sum == '0);
    sum_bad_o  = wide_sum[SUM_W-1] || (wide_sum > limit);
    dec_o      = count_i - CNT_W'(1);
    at_floor_o = (SUM_W'(count_i) <= -limit);
    is_one_o   = (count_i == CNT_W'(1));
  end
endmodule

// File: rtl/iat_classify.sv
module iat_classify
  import inv_ack_pkg::*;
(
  input  logic       valid_i,
  input  logic       alloc_i,
  input  logic       present_i,
  input  logic       from_dir_i,
  input  logic [1:0] kind_i,
  input  logic       sum_zero_i,
  input  logic       sum_bad_i,
  input  logic       at_floor_i,
  input  logic       is_one_i,
  output evt_e       evt_o,
  output err_e       err_o
);
  always_comb begin
    evt_o = EV_NONE;
    err_o = ER_NONE;
    if (valid_i) begin
      if (!present_i || alloc_i) begin
        err_o = ER_NOREC;
      end else if (from_dir_i) begin
        if (kind_i != KIND_DATA)  err_o = ER_DIRTYPE;
        else if (sum_bad_i)       err_o = ER_RANGE;
        else if (sum_zero_i)      evt_o = EV_DIR_CLEAR;
        else                      evt_o = EV_DIR_WAIT;
      end else begin
        if (kind_i == KIND_DATA)        evt_o = EV_OWNER;
        else if (kind_i == KIND_INVACK) begin
          if (is_one_i)        evt_o = EV_LAST;
          else if (at_floor_i) err_o = ER_UNDER;
          else                 evt_o = EV_ACK;
        end else                        err_o = ER_PEERTYPE;
      end
    end
  end
endmodule

// File: rtl/inv_ack_tracker.sv
module inv_ack_tracker
  import inv_ack_pkg::*;
#(
  parameter int MAX_SHARERS = 15,
  localparam int ACK_W = $clog2(MAX_SHARERS + 1),
  localparam int CNT_W = ACK_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_i,
  input  logic                    rsp_valid_i,
  input  logic                    rsp_from_dir_i,
  input  logic [1:0]              rsp_kind_i,
  input  logic [ACK_W-1:0]        rsp_acks_i,
  input  logic                    rec_present_i,
  input  logic signed [CNT_W-1:0] rec_count_i,
  output logic [2:0]              evt_o,
  output logic [2:0]              err_o,
  output logic                    cnt_we_o,
  output logic signed [CNT_W-1:0] cnt_new_o
);
  logic signed [CNT_W-1:0] sum, dec;
  logic sum_zero, sum_bad, at_floor, is_one;
  evt_e evt_d;
  err_e err_d;
  logic we_d;
  logic signed [CNT_W-1:0] new_d;
  logic live_q;

  iat_count_math #(.MAX_SHARERS(MAX_SHARERS)) u_math (
    .count_i(rec_count_i), .acks_i(rsp_acks_i), .sum_o(sum),
    .sum_zero_o(sum_zero), .sum_bad_o(sum_bad), .dec_o(dec),
    .at_floor_o(at_floor), .is_one_o(is_one)
  );

  iat_classify u_cls (
    .valid_i(rsp_valid_i), .alloc_i(alloc_i), .present_i(rec_present_i),
    .from_dir_i(rsp_from_dir_i), .kind_i(rsp_kind_i),
    .sum_zero_i(sum_zero), .sum_bad_i(sum_bad), .at_floor_i(at_floor),
    .is_one_i(is_one), .evt_o(evt_d), .err_o(err_d)
  );

  // Counter write-back selection.
  always_comb begin
    we_d  = 1'b0;
    new_d = '0;
    if (alloc_i) begin
      we_d = 1'b1;
    end else begin
      unique case (evt_d)
        EV_DIR_CLEAR, EV_LAST: we_d = 1'b1;
        EV_DIR_WAIT: begin we_d = 1'b1; new_d = sum; end
        EV_ACK:      begin we_d = 1'b1; new_d = dec; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_o     <= '0;
      err_o     <= '0;
      cnt_we_o  <= 1'b0;
      cnt_new_o <= '0;
      live_q    <= 1'b0;
    end else begin
      evt_o     <= evt_d;
      err_o     <= err_d;
      cnt_we_o  <= we_d;
      cnt_new_o <= new_d;
      live_q    <= 1'b1;
    end
  end

  // R1: allocation clears the counter on the next cycle
  assert_alloc_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(alloc_i) |-> cnt_we_o && cnt_new_o == '0 && evt_o == 3'd0);

  // R3: a final ack always leaves the counter at zero
  assert_last_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o == 3'd5 |-> cnt_we_o && cnt_new_o == '0);

  // R5: a pending-acks directory reply stores a positive count
  assert_wait_positive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o == 3'd2 |-> cnt_we_o && cnt_new_o > 0);

  // R6: an error never produces an event or a counter write
  assert_error_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o != 3'd0 && !(live_q && $past(alloc_i)) |-> evt_o == 3'd0 && !cnt_we_o);

  // R9: a response without a record is flagged
  assert_norec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(rsp_valid_i && !rec_present_i) |-> err_o == 3'd1);

  // R11: idle input yields idle output
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(!rsp_valid_i && !alloc_i) |-> evt_o == 3'd0 && err_o == 3'd0 && !cnt_we_o);
endmodule

// File: tb/tb_inv_ack_tracker.sv
module tb_inv_ack_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 7;
  localparam int ACK_W = $clog2(MAXS + 1);
  localparam int CNT_W = ACK_W + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc, vld, fdir, pres;
  logic [1:0] kind;
  logic [ACK_W-1:0] acks;
  logic signed [CNT_W-1:0] cnt;
  logic [2:0] evt, err;
  logic we;
  logic signed [CNT_W-1:0] cnew;

  int n_checks = 0, n_fail = 0;
  int e_evt, e_err, e_we, e_new;
  string e_tag;
  int line_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_ack_tracker #(.MAX_SHARERS(MAXS)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .rsp_valid_i(vld),
    .rsp_from_dir_i(fdir), .rsp_kind_i(kind), .rsp_acks_i(acks),
    .rec_present_i(pres), .rec_count_i(cnt), .evt_o(evt), .err_o(err),
    .cnt_we_o(we), .cnt_new_o(cnew)
  );

  task automatic check_out();
    n_checks++;
    if (int'(evt) != e_evt || int'(err) != e_err || int'(we) != e_we ||
        (e_we == 1 && int'(cnew) != e_new)) begin
      n_fail++;
      $display("FAIL %s: got evt=%0d err=%0d we=%0d new=%0d exp evt=%0d err=%0d we=%0d new=%0d",
               e_tag, evt, err, we, cnew, e_evt, e_err, e_we, e_new);
    end
  endtask

  // Behavioural expectation from the requirements.
  task automatic model(input bit a, input bit v, input bit d, input int k,
                       input int n, input bit p, input int c);
    int s;
    e_evt = 0; e_err = 0; e_we = 0; e_new = 0; e_tag = "R11 idle";
    if (a) begin e_we = 1; e_new = 0; e_tag = "R1 alloc"; end
    if (v) begin
      s = n + c;
      if (!p || a) begin e_err = 1; e_tag = "R9 no record"; end
      else if (d) begin
        if (k != 0) begin e_err = 2; e_tag = "R8 dir type"; end
        else if (s < 0 || s > MAXS) begin e_err = 4; e_tag = "R6 sum range"; end
        else if (s == 0) begin e_evt = 1; e_we = 1; e_new = 0; e_tag = "R4 dir clear"; end
        else begin e_evt = 2; e_we = 1; e_new = s; e_tag = "R5 dir wait"; end
      end else begin
        if (k == 0) begin e_evt = 3; e_tag = "R7 owner"; end
        else if (k == 1) begin
          if (c == 1) begin e_evt = 5; e_we = 1; e_new = 0; e_tag = "R3 last ack"; end
          else if (c <= -MAXS) begin e_err = 5; e_tag = "R10 underflow"; end
          else begin e_evt = 4; e_we = 1; e_new = c - 1; e_tag = "R2 ack"; end
        end else begin e_err = 3; e_tag = "R8 peer type"; end
      end
    end
  endtask

  // One vector: check the previous one, then drive and predict this one.
  task automatic step(input bit a, input bit v, input bit d, input int k,
                      input int n, input bit p, input int c);
    @(negedge clk);
    check_out();
    alloc = a; vld = v; fdir = d; kind = 2'(k); acks = ACK_W'(n);
    pres = p; cnt = CNT_W'(c);
    model(a, v, d, k, n, p, c);
  endtask

  // Peer ack applied to a tracked counter, updating it as the table would.
  task automatic peer_ack();
    step(0, 1, 0, 1, 0, 1, line_cnt);
    if (e_we == 1) line_cnt = e_new;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc = 0; vld = 0; fdir = 0; kind = 0; acks = 0;
    pres = 0; cnt = 0;
    e_evt = 0; e_err = 0; e_we = 0; e_new = 0; e_tag = "R11 reset";
    repeat (3) @(negedge clk);
    check_out();
    rst_n = 1'b1;

    // Acks before data: alloc, two early acks, directory says 3 -> wait 1, last ack
    step(1, 0, 0, 0, 0, 0, 0); line_cnt = 0;
    peer_ack(); peer_ack();
    step(0, 1, 1, 0, 3, 1, line_cnt); line_cnt = e_new;
    peer_ack();
    // Data first with 2 acks, then ack, last ack
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 2, 1, 0);
    step(0, 1, 0, 1, 0, 1, 2);
    step(0, 1, 0, 1, 0, 1, 1);
    // All acks early: -2 + 2 -> clear
    step(0, 1, 1, 0, 2, 1, -2);
    step(0, 1, 1, 0, 0, 1, 0);
    // Owner data, type errors, no record, alloc collision
    step(0, 1, 0, 0, 5, 1, 0);
    step(0, 1, 1, 1, 0, 1, 0);
    step(0, 1, 1, 3, 0, 1, 0);
    step(0, 1, 0, 2, 0, 1, 0);
    step(0, 1, 0, 3, 0, 1, -1);
    step(0, 1, 0, 1, 0, 0, 1);
    step(1, 1, 1, 0, 2, 1, 0);
    // Range edges: negative sum, sum above max, sum at max
    step(0, 1, 1, 0, 1, 1, -3);
    step(0, 1, 1, 0, 7, 1, 1);
    step(0, 1, 1, 0, 7, 1, 0);
    step(0, 1, 1, 0, 0, 1, -8);
    // Underflow floor and just above it
    step(0, 1, 0, 1, 0, 1, -7);
    step(0, 1, 0, 1, 0, 1, -8);
    step(0, 1, 0, 1, 0, 1, -6);
    step(0, 1, 0, 1, 0, 1, 7);
    step(0, 0, 1, 1, 3, 1, 1);
    // Random sweep
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) == 0, ($urandom % 5) != 0, $urandom % 2,
           $urandom % 4, $urandom % 8, ($urandom % 8) != 0,
           int'($urandom % 16) - 8);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_out();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule